// File: doc/BRIEF.md
# Timed Average Pulse Period Meter

This block measures the mean rate of a pulse train over a fixed span of reference clock cycles. Software sets the span length in ticks of the reference clock and picks which transition of the input counts, rising or falling. Inside each span the block records how many ticks separate the first counted transition from the last one, and how many whole periods lie between them. Dividing the tick result by the period result gives the average period in reference ticks. Because the timing runs from edge to edge, the result carries no error from a partial period at either end of the span.

A span opens when the enable is raised, or when a start pulse arrives while the block is enabled. When a span ends, the two results are published with a one-cycle valid strobe and the next span begins at once, so spans follow one another with no gap. The input must already be synchronized to the reference clock. Debounce, register access and interrupt routing belong to the surrounding logic.

Top module: `tppm_meter`

## Requirements
- R1: A span opens in a clock where `en_i` is high and either `en_i` was low in the previous clock or `start_i` is high. That opening clock is not part of the span. The span covers the next `win_len_i` clocks, and a `win_len_i` of 0 acts as 1.
- R2: With `edge_sel_i` = 0 a counted edge is a 0-to-1 change of `sig_i` between two consecutive clock samples. With `edge_sel_i` = 1 it is a 1-to-0 change.
- R3: `ticks_o` reports the number of clocks from the first counted edge of the span to the last counted edge of the span.
- R4: `count_o` reports the number of counted edges in the span minus one, which is the number of whole periods covered by `ticks_o`.
- R5: A span with fewer than two counted edges reports 0 on both `ticks_o` and `count_o`.
- R6: `valid_o` is high for exactly one clock, in the clock after the last clock of a span. `ticks_o` and `count_o` change only in that clock and hold their values at all other times.
- R7: Spans follow one another with no gap. An edge seen in the last clock of a span belongs to that span.
- R8: A `start_i` pulse while a span is running drops the partial span without reporting it, and opens a new span.
- R9: While `en_i` is low no span runs and `valid_o` stays low. A partial span is dropped without reporting it, and `ticks_o` and `count_o` keep their last values.
- R10: After reset `ticks_o`, `count_o` and `valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low holds the block idle |
| start_i | input | 1 | Restart pulse, opens a new span |
| sig_i | input | 1 | Synchronized pulse input |
| edge_sel_i | input | 1 | 0 counts rising edges, 1 counts falling edges |
| win_len_i | input | 32 | Span length in reference clocks |
| ticks_o | output | 32 | Clocks from first to last counted edge |
| count_o | output | 32 | Counted edges minus one |
| valid_o | output | 1 | One-clock strobe when the results update |

## Verification
If a span opens at clock edge 0, it covers edges 1 to L. Its results and strobe appear after edge L and are sampled at the falling edge that follows. In general, the strobe from clock edge k·L is sampled at the falling edge of index k·L+1. The bench keeps its own count of clock edges since each opening, and it predicts each span's result from the edges it drove itself. At every falling edge it checks the strobe, and in strobe cycles it also checks both results. For the restart, disable and final-clock cases, the bench lists the exact falling edge where the result is due and requires the strobe to stay low everywhere else.

// File: rtl/tppm_pkg.sv
package tppm_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/tppm_edge_detect.sv
module tppm_edge_detect
  import tppm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic sel_i,
  output logic edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  always_comb begin
    if (edge_sel_e'(sel_i) == EDGE_FALL) edge_o = sig_q & ~sig_i;
    else                                 edge_o = ~sig_q & sig_i;
  end
endmodule

// File: rtl/tppm_window_timer.sv
module tppm_window_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         run_i,
  input  logic         open_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last_idx;

  // zero length behaves as one clock
  assign last_idx = (len_i == '0) ? '0 : len_i - 1'b1;
  assign expire_o = en_i & run_i & ~open_i & (cnt_q >= last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!en_i || open_i || expire_o) cnt_q <= '0;
    else if (run_i)                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tppm_interval_track.sv
module tppm_interval_track #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         act_i,
  input  logic         edge_i,
  input  logic         expire_i,
  output logic [W-1:0] ticks_nx_o,
  output logic [W-1:0] pulses_nx_o
);
  logic         seen_q;
  logic [W-1:0] icnt_q, pcnt_q, last_q;
  logic         hit, first, later;
  logic [W-1:0] icnt_nx, pcnt_nx, last_nx;

  assign hit   = act_i & edge_i;
  assign first = hit & ~seen_q;
  assign later = hit & seen_q;

  always_comb begin
    icnt_nx = first ? '0 : icnt_q + 1'b1;
    pcnt_nx = first ? '0 : (later ? pcnt_q + 1'b1 : pcnt_q);
    // interval ends at this edge: distance is icnt_q + 1
    last_nx = first ? '0 : (later ? icnt_q + 1'b1 : last_q);
  end

  assign ticks_nx_o  = last_nx;
  assign pulses_nx_o = pcnt_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      icnt_q <= '0;
      pcnt_q <= '0;
      last_q <= '0;
    end else if (clr_i || expire_i) begin
      seen_q <= 1'b0;
      icnt_q <= '0;
      pcnt_q <= '0;
      last_q <= '0;
    end else if (act_i) begin
      seen_q <= seen_q | hit;
      icnt_q <= icnt_nx;
      pcnt_q <= pcnt_nx;
      last_q <= last_nx;
    end
  end
endmodule

// File: rtl/tppm_meter.sv
module tppm_meter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         start_i,
  input  logic         sig_i,
  input  logic         edge_sel_i,
  input  logic [W-1:0] win_len_i,
  output logic [W-1:0] ticks_o,
  output logic [W-1:0] count_o,
  output logic         valid_o
);
  logic         run_q;
  logic         open_w, act_w, clr_w, edge_w, expire_w;
  logic [W-1:0] ticks_nx, pulses_nx;

  assign open_w = en_i & (~run_q | start_i);
  assign act_w  = en_i & run_q & ~open_w;
  assign clr_w  = ~en_i | open_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  tppm_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .sel_i  (edge_sel_i),
    .edge_o (edge_w)
  );

  tppm_window_timer #(.W(W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .run_i    (run_q),
    .open_i   (open_w),
    .len_i    (win_len_i),
    .expire_o (expire_w)
  );

  tppm_interval_track #(.W(W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_w),
    .act_i       (act_w),
    .edge_i      (edge_w),
    .expire_i    (expire_w),
    .ticks_nx_o  (ticks_nx),
    .pulses_nx_o (pulses_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ticks_o <= '0;
      count_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= expire_w;
      if (expire_w) begin
        ticks_o <= ticks_nx;
        count_o <= pulses_nx;
      end
    end
  end
endmodule

// File: rtl/tppm_meter_chk.sv
module tppm_meter_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [W-1:0] win_len_i,
  input logic [W-1:0] ticks_o,
  input logic [W-1:0] count_o,
  input logic         valid_o
);
  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (win_len_i > 1) |=> !valid_o);

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(ticks_o) && $stable(count_o));

  // R5
  short_span_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (count_o == '0) |-> (ticks_o == '0));

  // R3
  tick_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ticks_o >= count_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
endmodule

bind tppm_meter tppm_meter_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .win_len_i (win_len_i),
  .ticks_o   (ticks_o),
  .count_o   (count_o),
  .valid_o   (valid_o)
);

// File: tb/sim_tppm_meter.sv
module sim_tppm_meter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        start_i = 1'b0;
  logic        sig_i = 1'b0;
  logic        edge_sel_i = 1'b0;
  logic [31:0] win_len_i = 32'd4;
  logic [31:0] ticks_o, count_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tppm_meter #(.W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .start_i(start_i),
    .sig_i(sig_i), .edge_sel_i(edge_sel_i), .win_len_i(win_len_i),
    .ticks_o(ticks_o), .count_o(count_o), .valid_o(valid_o)
  );

  // {span length, edge select, period, high time, spans}; period 0 = no edges
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{20, 0, 4, 2, 3},
    '{20, 1, 5, 2, 3},
    '{16, 0, 10, 5, 3},
    '{10, 0, 0, 0, 2},
    '{12, 0, 2, 1, 3},
    '{8, 1, 3, 1, 3},
    '{1, 0, 2, 1, 4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drop();
    en_i = 1'b0; start_i = 1'b0; sig_i = 1'b0;
    @(negedge clk);
  endtask

  // R2 R3 R4 R5 R6 R7: periodic input, span results predicted from driven edges
  task automatic run_vec(input int L, input int sel, input int P, input int H, input int nw);
    int first, last, n, et, ec;
    logic prev, s, hit;
    drop();
    n = 0; first = 0; last = 0; et = 0; ec = 0; prev = 1'b0;
    for (int j = 0; j <= nw * L + 1; j++) begin
      if (j > 0) @(negedge clk);
      if (j >= 2) begin
        if ((j - 1) % L == 0) begin
          chk("R6 strobe", {31'd0, valid_o}, 32'd1);
          chk("R3 R2 ticks", ticks_o, et);
          chk("R4 R5 R7 count", count_o, ec);
        end else begin
          chk("R6 R7 no strobe", {31'd0, valid_o}, 32'd0);
        end
      end
      if (j <= nw * L) begin
        s = (P == 0) ? 1'b0 : ((j % P) < H);
        en_i = 1'b1; edge_sel_i = sel[0]; win_len_i = L; sig_i = s;
        if (j >= 1) begin
          hit = sel[0] ? (prev & ~s) : (~prev & s);
          if (hit) begin
            if (n == 0) first = j;
            last = j;
            n++;
          end
          if (j % L == 0) begin
            et = (n >= 2) ? last - first : 0;
            ec = (n >= 2) ? n - 1 : 0;
            n = 0;
          end
        end
        prev = s;
      end
    end
  endtask

  // single-clock high pulses at e0..e3 (rising edges), optional start and disable
  task automatic dir_run(input string tag, input int L, input int e0, input int e1,
                         input int e2, input int e3, input int st_at, input int dis_at,
                         input int exp_at, input int et, input int ec, input int last_j,
                         input bit hold);
    drop();
    for (int j = 0; j <= last_j; j++) begin
      if (j > 0) @(negedge clk);
      if (j >= 1) begin
        chk({tag, " strobe"}, {31'd0, valid_o}, (j - 1 == exp_at) ? 32'd1 : 32'd0);
        if (j - 1 == exp_at || hold) begin
          chk({tag, " ticks"}, ticks_o, et);
          chk({tag, " count"}, count_o, ec);
        end
      end
      en_i       = !(dis_at >= 0 && j >= dis_at);
      start_i    = (j == st_at);
      sig_i      = (j == e0 || j == e1 || j == e2 || j == e3);
      edge_sel_i = 1'b0;
      win_len_i  = L;
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 ticks", ticks_o, 32'd0);
    chk("R10 count", count_o, 32'd0);
    chk("R10 strobe", {31'd0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 strobe after release", {31'd0, valid_o}, 32'd0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

    // R8 R1: restart mid-span drops edges 2,4; new span 7..16 sees 9 and 14
    dir_run("R8 R1", 10, 2, 4, 9, 14, 6, -1, 16, 5, 1, 17, 1'b0);
    // R9: disable mid-span, results keep 5/1, no strobe
    dir_run("R9", 10, 2, 5, -1, -1, -1, 7, -1, 5, 1, 25, 1'b1);
    // R7: edge in the final clock of the span belongs to it
    dir_run("R7", 6, 1, 6, -1, -1, -1, -1, 6, 5, 1, 7, 1'b0);
    // R5: single edge reports zeros
    dir_run("R5", 8, 3, -1, -1, -1, -1, -1, 8, 0, 0, 9, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule